// File: doc/BRIEF.md
# Variable-Length Branch Decoder and Target Generator

This block receives the 16-bit words of one branch instruction, one word per accepted handshake. It decides whether the branch is taken and how many bytes the instruction occupies, and it forms the 32-bit PC-relative destination. The first word is the opcode. Its upper nibble marks it as a branch, and the next nibble selects a condition, which is tested against the N, Z, V and C flags. The low byte of the opcode either holds a short displacement itself or acts as a sentinel. A sentinel tells a small sequencer to gather one or two extension words before the destination is formed.

A fetch or decode stage feeds words with `word_valid`. It supplies the opcode's own address and the current flags together with the opcode word. When the last word has been taken, the block emits a single-cycle `done` together with the taken flag, the length and the destination. These results stay on the outputs until the next `done`. A first word that is not a branch produces a one-cycle `not_branch` pulse, and the block goes on waiting for an opcode.

Top module: `branch_target_unit`

## Requirements
- R1: A synchronous reset, including one applied partway through an instruction, clears `done`, `taken`, `unsupported` and `not_branch` to 0. The next accepted word is then treated as a fresh opcode.
- R2: A first word whose bits [15:12] are not 4'b0110 pulses `not_branch` for exactly one cycle, one cycle after it is accepted. It never raises `done` and consumes no further words.
- R3: When the opcode's low byte (bits [7:0]) is neither 8'h00 nor 8'hFF, it is a signed 8-bit displacement. No extension word follows, `done` rises in the cycle after the opcode is accepted, and `instr_len` is 2.
- R4: A low byte of 8'h00 makes the block take exactly one extension word, read as a signed 16-bit displacement. `instr_len` is then 4.
- R5: A low byte of 8'hFF makes the block take two extension words, the upper half first and the lower half second, forming a 32-bit displacement. `instr_len` is then 6.
- R6: `target` equals the opcode address plus 2 plus the displacement sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R7: Condition field bits [11:8] = 4'b0000 always reports `taken` = 1.
- R8: Condition field 4'b0001 reports `unsupported` = 1 and `taken` = 0. Its extension words are still consumed, and its length and target are still reported.
- R9: The other condition codes set `taken` as follows. 2: !C&!Z. 3: C|Z. 4: !C. 5: C. 6: !Z. 7: Z. 8: !V. 9: V. A: !N. B: N. C: N==V. D: N!=V. E: !Z&(N==V). F: Z|(N!=V).
- R10: `done` is high for one cycle after the final word is accepted. Idle cycles between words are waited out. `taken`, `unsupported`, `instr_len` and `target` hold their values until the next `done`.
- R11: The flags and the opcode address are sampled only with the opcode word. Values presented on those inputs alongside extension words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | A word is presented on `word_in` this cycle |
| word_in | input | 16 | Instruction word |
| op_addr | input | 32 | Address of the opcode word, used with the opcode |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| done | output | 1 | One-cycle pulse: the branch results are valid |
| taken | output | 1 | Branch is taken |
| unsupported | output | 1 | Condition code outside the supported set |
| not_branch | output | 1 | One-cycle pulse: the first word was not a branch |
| instr_len | output | 3 | Instruction length in bytes (2, 4 or 6) |
| target | output | 32 | Branch destination address |

## Verification
The assertions assume that reset is held for at least one clock edge before any word arrives. They also assume that `word_valid` is always 0 or 1 and never unknown, and that flags and address are meaningful in the cycle the opcode is presented. The bench sets every input at its declaration, holds reset for three cycles, and changes inputs only on falling edges. It deliberately drives garbage address and inverted flags with every extension word, so that R11 is tested rather than assumed.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EXT16,
      ST_EXT32_HI,
      ST_EXT32_LO
   } brtgt_state_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } brtgt_flags_t;

   localparam logic [3:0] BR_CLASS  = 4'b0110;
   localparam logic [7:0] SENT_WORD = 8'h00;
   localparam logic [7:0] SENT_LONG = 8'hFF;

   function automatic logic cond_holds(input logic [3:0] cc, input brtgt_flags_t f);
      logic r;
      case (cc)
         4'h0: r = 1'b1;
         4'h1: r = 1'b0;
         4'h2: r = !f.c && !f.z;
         4'h3: r = f.c || f.z;
         4'h4: r = !f.c;
         4'h5: r = f.c;
         4'h6: r = !f.z;
         4'h7: r = f.z;
         4'h8: r = !f.v;
         4'h9: r = f.v;
         4'hA: r = !f.n;
         4'hB: r = f.n;
         4'hC: r = (f.n == f.v);
         4'hD: r = (f.n != f.v);
         4'hE: r = !f.z && (f.n == f.v);
         default: r = f.z || (f.n != f.v);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/brtgt_cond.sv
module brtgt_cond
   import brtgt_pkg::*;
#(
   parameter logic [3:0] UNSUP_CC = 4'b0001
) (
   input  logic [3:0]   cc,
   input  brtgt_flags_t flags,
   output logic         hit,
   output logic         unsup
);
   localparam int NUM_CC = 16;

   logic [NUM_CC-1:0] hit_vec;

   for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
      assign hit_vec[i] = cond_holds(4'(i), flags);
   end

   assign hit   = hit_vec[cc];
   assign unsup = (cc == UNSUP_CC);

endmodule

// File: rtl/brtgt_seq.sv
module brtgt_seq
   import brtgt_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   input  logic [ADDR_W-1:0] op_addr,
   input  brtgt_flags_t      flags_in,
   output logic              fin,
   output logic              non_br,
   output logic [3:0]        fin_cc,
   output brtgt_flags_t      fin_flags,
   output logic [ADDR_W-1:0] fin_base,
   output logic [ADDR_W-1:0] fin_disp,
   output logic [1:0]        fin_ext
);
   localparam int CLS_MSB = WORD_W - 1;
   localparam int CC_MSB  = WORD_W - 5;

   if (WORD_W < 16) begin : g_bad_word
      $error("brtgt_seq: WORD_W must be at least 16");
   end
   if (ADDR_W < 2 * WORD_W) begin : g_bad_addr
      $error("brtgt_seq: ADDR_W must hold two extension words");
   end

   brtgt_state_e      state, state_nx;
   logic [3:0]        cc_q;
   brtgt_flags_t      flags_q;
   logic [ADDR_W-1:0] base_q;
   logic [WORD_W-1:0] hi_q;

   logic       acc_op, is_br;
   logic [7:0] lo;

   assign acc_op = word_valid && (state == ST_IDLE);
   assign is_br  = (word_in[CLS_MSB -: 4] == BR_CLASS);
   assign non_br = acc_op && !is_br;
   assign lo     = word_in[7:0];

   always_comb begin
      state_nx  = state;
      fin       = 1'b0;
      fin_cc    = cc_q;
      fin_flags = flags_q;
      fin_base  = base_q;
      fin_disp  = '0;
      fin_ext   = 2'd0;
      case (state)
         ST_IDLE: begin
            if (word_valid && is_br) begin
               if (lo == SENT_WORD) begin
                  state_nx = ST_EXT16;
               end else if (lo == SENT_LONG) begin
                  state_nx = ST_EXT32_HI;
               end else begin
                  fin       = 1'b1;
                  fin_cc    = word_in[CC_MSB -: 4];
                  fin_flags = flags_in;
                  fin_base  = op_addr;
                  fin_disp  = ADDR_W'($signed(lo));
               end
            end
         end
         ST_EXT16: begin
            if (word_valid) begin
               fin      = 1'b1;
               fin_disp = ADDR_W'($signed(word_in));
               fin_ext  = 2'd1;
               state_nx = ST_IDLE;
            end
         end
         ST_EXT32_HI: begin
            if (word_valid) state_nx = ST_EXT32_LO;
         end
         default: begin
            if (word_valid) begin
               fin      = 1'b1;
               fin_disp = ADDR_W'($signed({hi_q, word_in}));
               fin_ext  = 2'd2;
               state_nx = ST_IDLE;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         cc_q    <= '0;
         flags_q <= '0;
         base_q  <= '0;
         hi_q    <= '0;
      end else begin
         state <= state_nx;
         if (acc_op && is_br) begin
            cc_q    <= word_in[CC_MSB -: 4];
            flags_q <= flags_in;
            base_q  <= op_addr;
         end
         if (state == ST_EXT32_HI && word_valid) hi_q <= word_in;
      end
   end

   // R5
   ext32_order_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXT32_LO) |-> ($past(state) == ST_EXT32_HI || $past(state) == ST_EXT32_LO));

   // R2
   nonbr_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
      non_br |=> (state == ST_IDLE));

   // R4
   ext16_returns_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXT16 && word_valid) |=> (state == ST_IDLE));

endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
   import brtgt_pkg::*;
#(
   parameter int         ADDR_W   = 32,
   parameter int         WORD_W   = 16,
   parameter logic [3:0] UNSUP_CC = 4'b0001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_v,
   input  logic              flag_c,
   output logic              done,
   output logic              taken,
   output logic              unsupported,
   output logic              not_branch,
   output logic [2:0]        instr_len,
   output logic [ADDR_W-1:0] target
);
   localparam logic [ADDR_W-1:0] BASE_OFS = ADDR_W'(WORD_W / 8);
   localparam logic [2:0]        LEN_MIN  = 3'(WORD_W / 8);

   brtgt_flags_t      flags_in, fin_flags;
   logic              fin, non_br, hit, unsup;
   logic [3:0]        fin_cc;
   logic [ADDR_W-1:0] fin_base, fin_disp;
   logic [1:0]        fin_ext;

   assign flags_in = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

   brtgt_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) seq_i (
      .clk       (clk),
      .rst       (rst),
      .word_valid(word_valid),
      .word_in   (word_in),
      .op_addr   (op_addr),
      .flags_in  (flags_in),
      .fin       (fin),
      .non_br    (non_br),
      .fin_cc    (fin_cc),
      .fin_flags (fin_flags),
      .fin_base  (fin_base),
      .fin_disp  (fin_disp),
      .fin_ext   (fin_ext)
   );

   brtgt_cond #(.UNSUP_CC(UNSUP_CC)) cond_i (
      .cc   (fin_cc),
      .flags(fin_flags),
      .hit  (hit),
      .unsup(unsup)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done        <= 1'b0;
         not_branch  <= 1'b0;
         taken       <= 1'b0;
         unsupported <= 1'b0;
         instr_len   <= '0;
         target      <= '0;
      end else begin
         done       <= fin;
         not_branch <= non_br;
         if (fin) begin
            taken       <= hit && !unsup;
            unsupported <= unsup;
            instr_len   <= LEN_MIN + {fin_ext, 1'b0};
            target      <= fin_base + BASE_OFS + fin_disp;
         end
      end
   end

   // R7
   uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (fin && fin_cc == 4'h0) |=> taken);

   // R8
   unsup_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (done && unsupported) |-> !taken);

   // R3
   len_legal_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (instr_len == 3'd2 || instr_len == 3'd4 || instr_len == 3'd6));

   // R2
   done_nb_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(done && not_branch));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !fin |=> ($stable(target) && $stable(taken) && $stable(instr_len)));

endmodule

// File: tb/branch_target_unit_tb.sv
`timescale 1ns/1ps
module branch_target_unit_tb_top;

   localparam int  HALF_NS  = 10;
   localparam int  WD_LIMIT = 200000;

   typedef struct packed {
      logic [15:0] op;
      logic [15:0] e1;
      logic [15:0] e2;
      logic [31:0] addr;
      logic [3:0]  nzvc;
      logic        exp_taken;
      logic        exp_unsup;
      logic [2:0]  exp_len;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [0:NV-1] = '{
      '{16'h6010, 16'h0000, 16'h0000, 32'h0000_1000, 4'b0000, 1'b1, 1'b0, 3'd2},
      '{16'h60FE, 16'h0000, 16'h0000, 32'h0000_2000, 4'b1111, 1'b1, 1'b0, 3'd2},
      '{16'h6000, 16'h8000, 16'h0000, 32'h0001_0000, 4'b0000, 1'b1, 1'b0, 3'd4},
      '{16'h60FF, 16'h0001, 16'h0000, 32'h0000_0000, 4'b0000, 1'b1, 1'b0, 3'd6},
      '{16'h6720, 16'h0000, 16'h0000, 32'h0000_0400, 4'b0100, 1'b1, 1'b0, 3'd2},
      '{16'h6720, 16'h0000, 16'h0000, 32'h0000_0400, 4'b0000, 1'b0, 1'b0, 3'd2},
      '{16'h6620, 16'h0000, 16'h0000, 32'h0000_0800, 4'b0000, 1'b1, 1'b0, 3'd2},
      '{16'h6200, 16'h0100, 16'h0000, 32'h0000_3000, 4'b0001, 1'b0, 1'b0, 3'd4},
      '{16'h6C05, 16'h0000, 16'h0000, 32'h0000_0100, 4'b1010, 1'b1, 1'b0, 3'd2},
      '{16'h6D05, 16'h0000, 16'h0000, 32'h0000_0100, 4'b1000, 1'b1, 1'b0, 3'd2},
      '{16'h6E05, 16'h0000, 16'h0000, 32'h0000_0100, 4'b0100, 1'b0, 1'b0, 3'd2},
      '{16'h6F05, 16'h0000, 16'h0000, 32'h0000_0100, 4'b0100, 1'b1, 1'b0, 3'd2},
      '{16'h61FF, 16'hFFFF, 16'hFFF0, 32'h0000_0100, 4'b0000, 1'b0, 1'b1, 3'd6},
      '{16'h6B80, 16'h0000, 16'h0000, 32'h0000_0200, 4'b1000, 1'b1, 1'b0, 3'd2},
      '{16'h6500, 16'h7FFF, 16'h0000, 32'h0000_0000, 4'b0001, 1'b1, 1'b0, 3'd4},
      '{16'h6A10, 16'h0000, 16'h0000, 32'h0000_0040, 4'b1000, 1'b0, 1'b0, 3'd2},
      '{16'h6810, 16'h0000, 16'h0000, 32'h0000_0040, 4'b0010, 1'b0, 1'b0, 3'd2},
      '{16'h6910, 16'h0000, 16'h0000, 32'h0000_0040, 4'b0010, 1'b1, 1'b0, 3'd2}
   };

   logic        clk        = 1'b0;
   logic        rst        = 1'b1;
   logic        word_valid = 1'b0;
   logic [15:0] word_in    = '0;
   logic [31:0] op_addr    = '0;
   logic        flag_n     = 1'b0;
   logic        flag_z     = 1'b0;
   logic        flag_v     = 1'b0;
   logic        flag_c     = 1'b0;
   logic        done, taken, unsupported, not_branch;
   logic [2:0]  instr_len;
   logic [31:0] target;

   int n_cmp = 0;
   int n_bad = 0;

   always #HALF_NS clk = ~clk;

   branch_target_unit dut_i (
      .clk        (clk),
      .rst        (rst),
      .word_valid (word_valid),
      .word_in    (word_in),
      .op_addr    (op_addr),
      .flag_n     (flag_n),
      .flag_z     (flag_z),
      .flag_v     (flag_v),
      .flag_c     (flag_c),
      .done       (done),
      .taken      (taken),
      .unsupported(unsupported),
      .not_branch (not_branch),
      .instr_len  (instr_len),
      .target     (target)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_word(input logic [15:0] w, input logic [31:0] a, input logic [3:0] f);
      @(negedge clk);
      word_valid = 1'b1;
      word_in    = w;
      op_addr    = a;
      {flag_n, flag_z, flag_v, flag_c} = f;
      @(negedge clk);
      word_valid = 1'b0;
   endtask

   // Extension words carry junk address and inverted flags (R11)
   task automatic run_branch(input logic [15:0] op, input logic [15:0] e1, input logic [15:0] e2,
                             input logic [31:0] a, input logic [3:0] f);
      put_word(op, a, f);
      if (op[7:0] == 8'h00) begin
         put_word(e1, 32'hDEAD_0000, ~f);
      end else if (op[7:0] == 8'hFF) begin
         put_word(e1, 32'hDEAD_0000, ~f);
         put_word(e2, 32'hBEEF_0000, ~f);
      end
   endtask

   function automatic logic [31:0] model_target(input logic [15:0] op, input logic [15:0] e1,
                                                input logic [15:0] e2, input logic [31:0] a);
      logic [31:0] d;
      if (op[7:0] == 8'h00)      d = {{16{e1[15]}}, e1};
      else if (op[7:0] == 8'hFF) d = {e1, e2};
      else                       d = {{24{op[7]}}, op[7:0]};
      return a + 32'd2 + d;
   endfunction

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk("R1 done",        {31'b0, done},        32'd0);
      chk("R1 taken",       {31'b0, taken},       32'd0);
      chk("R1 unsupported", {31'b0, unsupported}, 32'd0);
      chk("R1 not_branch",  {31'b0, not_branch},  32'd0);

      // R3 R4 R5 R6 R7 R8 R9 R11: table walk
      for (int i = 0; i < NV; i++) begin
         run_branch(VECS[i].op, VECS[i].e1, VECS[i].e2, VECS[i].addr, VECS[i].nzvc);
         chk("R10 done",          {31'b0, done},        32'd1);
         chk("R7/R9 taken",       {31'b0, taken},       {31'b0, VECS[i].exp_taken});
         chk("R8 unsupported",    {31'b0, unsupported}, {31'b0, VECS[i].exp_unsup});
         chk("R3/R4/R5 length",   {29'b0, instr_len},   {29'b0, VECS[i].exp_len});
         chk("R6 target",         target,
             model_target(VECS[i].op, VECS[i].e1, VECS[i].e2, VECS[i].addr));
      end

      // R10 hold after pulse
      held = target;
      @(negedge clk);
      chk("R10 done pulse ends", {31'b0, done}, 32'd0);
      chk("R10 target held",     target,        held);

      // R2 non-branch words
      put_word(16'h4E71, 32'h0000_0010, 4'b0000);
      chk("R2 not_branch pulse", {31'b0, not_branch}, 32'd1);
      chk("R2 no done",          {31'b0, done},       32'd0);
      @(negedge clk);
      chk("R2 pulse one cycle",  {31'b0, not_branch}, 32'd0);
      put_word(16'h7000, 32'h0000_0010, 4'b0000);
      chk("R2 not_branch 7xxx",  {31'b0, not_branch}, 32'd1);
      put_word(16'h6006, 32'h0000_0010, 4'b0000);
      chk("R2 idle after non-branch done", {31'b0, done}, 32'd1);
      chk("R2 idle after non-branch tgt",  target,        32'h0000_0018);

      // R10 gaps between opcode and extension word
      put_word(16'h6000, 32'h0000_0500, 4'b0000);
      for (int g = 0; g < 3; g++) begin
         @(negedge clk);
         chk("R10 no done during gap", {31'b0, done}, 32'd0);
      end
      put_word(16'h0010, 32'h0000_9990, 4'b1111);
      chk("R10 done after gap",  {31'b0, done},      32'd1);
      chk("R4 length after gap", {29'b0, instr_len}, 32'd4);
      chk("R11 target uses opcode addr", target,     32'h0000_0512);

      // R11 flags taken from the opcode word only
      run_branch(16'h6700, 16'h0020, 16'h0000, 32'h0000_0600, 4'b0100);
      chk("R11 flags sampled with opcode", {31'b0, taken}, 32'd1);

      // R6 wrap-around
      run_branch(16'h6020, 16'h0000, 16'h0000, 32'hFFFF_FFF0, 4'b0000);
      chk("R6 target wraps", target, 32'h0000_0012);

      // R1 reset mid-instruction
      put_word(16'h60FF, 32'h0000_0700, 4'b0000);
      put_word(16'h1234, 32'h0000_0700, 4'b0000);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 done after mid reset",   {31'b0, done},  32'd0);
      chk("R1 taken after mid reset",  {31'b0, taken}, 32'd0);
      put_word(16'h6002, 32'h0000_0040, 4'b0000);
      chk("R1 fresh opcode done",   {31'b0, done},      32'd1);
      chk("R1 fresh opcode length", {29'b0, instr_len}, 32'd2);
      chk("R1 fresh opcode target", target,             32'h0000_0044);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule